// File: doc/BRIEF.md
# Claim-Complete Interrupt Aggregator

The block collects level-sensitive interrupt lines from a cluster of processing elements, each of which drives several lines, and folds them onto a small set of target lines that feed a parent interrupt controller. Every target owns a source mask that picks which lines may raise it, and a claim/complete register that software uses to take and retire interrupts one at a time.

Software handles a target by reading its claim/complete register repeatedly. Each read returns the lowest-numbered source that is enabled for that target, pending and not yet taken, and marks that source as taken. A taken source is hidden from every target until software writes its number back to a claim/complete register. A read value of 0 means nothing is left to take. Source numbers run from 1 upwards, so the value 0 never names a source.

Top module: `irq_claim_agg`

## Requirements
- R1: After reset every target line is low, every source mask reads 0, no source is taken, and a claim read returns 0.
- R2: A write with `addr_i[0]`=0 loads the source mask of the target selected by `addr_i[TGT_W:1]` from `wdata_i[NUM_SRC-1:0]`. A read of the same address returns that mask, zero-extended, on `rdata_o` in the cycle after the read.
- R3: Source line k (bit k of `src_i`) can raise, and be returned by, a target only while bit k of that target's mask is 1.
- R4: A read with `addr_i[0]`=1 returns, in the next cycle, the number k+1 of the lowest bit k of `src_i` that is pending, enabled for the selected target and not taken. Line l of element p is bit p*LINES_PER_PE+l. The read returns 0 when no such bit exists.
- R5: A claim read that returns a nonzero number marks that source as taken. A taken source is returned by no target and holds no target line high.
- R6: Writing a taken source's number to the claim/complete register of any target frees that source from the next cycle onwards.
- R7: A completion write of 0, of a value above NUM_SRC, or of the number of a source that is not taken changes nothing.
- R8: Target line t is high exactly while some source is pending, enabled in mask t and not taken.
- R9: A taken source stays taken while its line drops and rises again, and it is reported again only after it has been freed and while it is still pending.
- R10: Register addresses are {target index, select}, with select 0 for the mask and select 1 for claim/complete. Reads and writes take effect at the clock edge on which the enable is sampled, and at most one of them is active in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_PE*LINES_PER_PE | Level interrupt lines from the cluster |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | $clog2(NUM_TGT)+1 | {target index, select} |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered |
| irq_o | output | NUM_TGT | Target lines to the parent controller |

## Verification
The assertions assume that read and write strobes are never raised in the same cycle, and one of them checks this. They also assume that the source lines are plain levels, sampled only at the clock edge. The bench follows both rules. It drives every strobe, address and source change just after a falling edge, keeps each strobe to a single cycle, and never overlaps a read with a write. It samples results at the next falling edge, against a reference model kept in step with the operations it issues.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic {REG_MASK = 1'b0, REG_CLAIM = 1'b1} reg_sel_e;

  function automatic int unsigned id_width(int unsigned n_src);
    return $clog2(n_src + 1);
  endfunction
endpackage

// File: rtl/irq_agg_claim.sv
module irq_agg_claim #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned ID_W    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic [ID_W-1:0]    set_id_i,
  input  logic               rel_i,
  input  logic [ID_W-1:0]    rel_id_i,
  output logic [NUM_SRC-1:0] claimed_o
);
  logic [NUM_SRC-1:0] claimed_q, set_vec, rel_vec;

  // one-hot decode; ids outside 1..NUM_SRC match no bit
  always_comb begin
    set_vec = '0;
    rel_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (set_i && set_id_i == ID_W'(i + 1)) set_vec[i] = 1'b1;
      if (rel_i && rel_id_i == ID_W'(i + 1) && claimed_q[i]) rel_vec[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) claimed_q <= '0;
    else         claimed_q <= (claimed_q & ~rel_vec) | set_vec;
  end

  assign claimed_o = claimed_q;

  assert_set_sticks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && set_id_i != '0) |=>
      |(claimed_q & (NUM_SRC'(1) << ($past(set_id_i) - ID_W'(1)))));

  assert_release_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !set_i && rel_id_i != '0 && rel_id_i <= ID_W'(NUM_SRC)) |=>
      !(|(claimed_q & (NUM_SRC'(1) << ($past(rel_id_i) - ID_W'(1))))));

  assert_zero_release_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !set_i && rel_id_i == '0) |=> $stable(claimed_q));
endmodule

// File: rtl/irq_agg_target.sv
module irq_agg_target #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned ID_W    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] claimed_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [ID_W-1:0]    id_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] mask_q, elig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  assign elig = src_i & mask_q & ~claimed_i;

  // lowest index wins: scan downwards so the last hit is the smallest
  always_comb begin
    id_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) id_o = ID_W'(i + 1);
    end
  end

  assign irq_o  = |elig;
  assign mask_o = mask_q;

  assert_lowest_pick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_o != '0) |->
      (|(elig & (NUM_SRC'(1) << (id_o - ID_W'(1))))) &&
      ((elig & ((NUM_SRC'(1) << (id_o - ID_W'(1))) - NUM_SRC'(1))) == '0));

  assert_mask_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_q == $past(mask_wdata_i));

  assert_idle_no_id_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> id_o == '0);
endmodule

// File: rtl/irq_claim_agg.sv
module irq_claim_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_PE       = 4,
  parameter int unsigned LINES_PER_PE = 4,
  parameter int unsigned NUM_TGT      = 4,
  parameter int unsigned DATA_W       = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PE*LINES_PER_PE-1:0] src_i,
  input  logic                           rd_en_i,
  input  logic                           wr_en_i,
  input  logic [$clog2(NUM_TGT):0]       addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [NUM_TGT-1:0]             irq_o
);
  localparam int unsigned NUM_SRC = NUM_PE * LINES_PER_PE;
  localparam int unsigned ID_W    = id_width(NUM_SRC);
  localparam int unsigned TGT_W   = $clog2(NUM_TGT);

  logic [TGT_W-1:0]   tgt_idx;
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] mask_vec [NUM_TGT];
  logic [ID_W-1:0]    id_vec   [NUM_TGT];
  logic [NUM_SRC-1:0] claimed;
  logic [DATA_W-1:0]  rd_mux, rdata_q;
  logic [ID_W-1:0]    sel_id;
  logic               tgt_hit, claim_rd, rel_wr;

  assign tgt_idx = addr_i[TGT_W:1];
  assign sel     = reg_sel_e'(addr_i[0]);

  always_comb begin
    rd_mux  = '0;
    sel_id  = '0;
    tgt_hit = 1'b0;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (tgt_idx == TGT_W'(t)) begin
        tgt_hit = 1'b1;
        sel_id  = id_vec[t];
        rd_mux  = (sel == REG_MASK) ? DATA_W'(mask_vec[t]) : DATA_W'(id_vec[t]);
      end
    end
  end

  assign claim_rd = rd_en_i && sel == REG_CLAIM && tgt_hit;
  // values wider than an id are out of range and never release
  assign rel_wr   = wr_en_i && sel == REG_CLAIM && tgt_hit && ((wdata_i >> ID_W) == '0);

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    irq_agg_target #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_tgt (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .mask_we_i    (wr_en_i && sel == REG_MASK && tgt_idx == TGT_W'(t)),
      .mask_wdata_i (wdata_i[NUM_SRC-1:0]),
      .src_i        (src_i),
      .claimed_i    (claimed),
      .mask_o       (mask_vec[t]),
      .id_o         (id_vec[t]),
      .irq_o        (irq_o[t])
    );
  end

  irq_agg_claim #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_claim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (claim_rd && sel_id != '0),
    .set_id_i  (sel_id),
    .rel_i     (rel_wr),
    .rel_id_i  (wdata_i[ID_W-1:0]),
    .claimed_o (claimed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= tgt_hit ? rd_mux : '0;
  end

  assign rdata_o = rdata_q;

  assert_bus_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && wr_en_i));

  assert_taken_not_offered_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_rd && sel_id != '0) |->
      !(|(claimed & (NUM_SRC'(1) << (sel_id - ID_W'(1))))));
endmodule

// File: tb/irq_claim_agg_tb_top.sv
`timescale 1ns/1ps
module irq_claim_agg_tb_top;
  localparam int NT = 4;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int cmp_cnt = 0;
  int err_cnt = 0;
  logic        rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference model
  logic [15:0] mask_m [NT];
  logic [15:0] taken_m = '0;

  always #4 clk = ~clk;

  irq_claim_agg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compare registered read data against the scoreboard
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      cmp_cnt++;
      if (rdata !== e) begin
        err_cnt++;
        $display("FAIL %s rdata actual=%0d expected=%0d", tg, rdata, e);
      end
    end
  end

  task automatic rd(input int t, input bit claim, input string tg);
    logic [31:0] e;
    logic [15:0] el;
    e = '0;
    if (!claim) e = 32'(mask_m[t]);
    else begin
      el = src & mask_m[t] & ~taken_m;
      for (int i = NS - 1; i >= 0; i--) if (el[i]) e = 32'(i + 1);
      if (e != 0) taken_m[e - 1] = 1'b1;
    end
    exp_q.push_back(e);
    tag_q.push_back(tg);
    addr  = 3'((t << 1) | int'(claim));
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input int t, input bit claim, input logic [31:0] d);
    if (!claim) mask_m[t] = d[15:0];
    else if (d != 0 && d <= NS && taken_m[d - 1]) taken_m[d - 1] = 1'b0;
    addr  = 3'((t << 1) | int'(claim));
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_irq(input string tg);
    logic [3:0] e;
    #1;
    for (int t = 0; t < NT; t++) e[t] = |(src & mask_m[t] & ~taken_m);
    cmp_cnt++;
    if (irq !== e) begin
      err_cnt++;
      $display("FAIL %s irq actual=%b expected=%b", tg, irq, e);
    end
  endtask

  initial begin
    for (int t = 0; t < NT; t++) mask_m[t] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_irq("R1");
    rd(0, 1, "R1");
    rd(2, 0, "R1");
    // R2 mask load and read back, R10 address map
    wr(0, 0, 32'h0000_00F0);
    wr(1, 0, 32'h0000_8001);
    rd(0, 0, "R2");
    rd(1, 0, "R2 R10");
    // R3 lines outside every mask stay invisible
    src = 16'h0102;
    chk_irq("R3");
    rd(0, 1, "R3");
    // R8 / R4 lowest pick
    wr(2, 0, 32'h0000_FFFF);
    chk_irq("R8");
    rd(2, 1, "R4");
    chk_irq("R8");
    rd(2, 1, "R4");
    chk_irq("R5");
    rd(2, 1, "R5");
    // R5 taken sources hidden from other targets
    wr(3, 0, 32'h0000_0102);
    chk_irq("R5");
    rd(3, 1, "R5");
    // R7 ignored completions
    wr(3, 1, 32'd0);
    wr(0, 1, 32'd20);
    wr(0, 1, 32'h0001_0002);
    wr(1, 1, 32'd5);
    rd(3, 1, "R7");
    chk_irq("R7");
    // R9 taken survives drop and re-raise
    src = 16'h0100;
    chk_irq("R9");
    src = 16'h0102;
    chk_irq("R9");
    rd(2, 1, "R9");
    // R6 completion through a different target
    wr(1, 1, 32'd9);
    chk_irq("R6");
    rd(3, 1, "R6");
    wr(0, 1, 32'd2);
    chk_irq("R6");
    rd(2, 1, "R6 R9");
    // R9 freed but no longer pending: not reported
    wr(2, 1, 32'd2);
    src = 16'h0100;
    rd(2, 1, "R9");
    // R4 across elements, R3 per target mask
    src = 16'hA000;
    chk_irq("R8");
    rd(1, 1, "R4 R3");
    rd(2, 1, "R4");
    rd(2, 1, "R5");
    wr(2, 1, 32'd16);
    wr(1, 1, 32'd14);
    wr(3, 1, 32'd9);
    chk_irq("R6");
    wr(2, 0, 32'h0000_0000);
    chk_irq("R3");
    rd(1, 1, "R4");
    rd(2, 0, "R2");
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, err_cnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    cmp_cnt++;
    err_cnt++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, err_cnt);
    $finish;
  end
endmodule